// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a PLL has settled by checking that its feedback clock runs at the expected multiple of its reference clock. A fast system clock samples both clocks. The block counts feedback rising edges over a window of a fixed number of reference periods and compares that count with an expected value. The result is a lock status bit. The analog loop and the divider chain are outside this block.

Lock uses hysteresis. A tight band must be met to acquire lock, and only a wider band of error makes it drop. Every change of the status bit, in either direction, sets a sticky interrupt flag. Software clears that flag by writing one to a clear input. The interrupt request is the flag gated by an enable.

A watchdog on the reference clock declares the reference lost when no reference edge has arrived for a programmable number of system cycles. When that happens, the lock bit is forced low and the measurement restarts.

Top module: `pll_lock_detector`

## Requirements
- R1: After reset, `lock`, `irq_flag`, `irq` and `ref_lost` are all 0.
- R2: A measurement window begins at a synchronized rising reference edge and spans WIN_REF reference periods. The window that is open at reset or at recovery is never judged, so `lock` stays 0 until one complete window has ended.
- R3: At the end of a window, an unlocked detector sets `lock` when the feedback rising-edge count `c` satisfies |c − FB_EXPECT| ≤ TOL_LOCK. Any larger error leaves it at 0.
- R4: At the end of a window, a locked detector clears `lock` only when |c − FB_EXPECT| > TOL_UNL (TOL_UNL ≥ TOL_LOCK). Errors between the two bands keep the present state. `lock` changes only at a window end or at a loss of reference.
- R5: Every change of `lock`, whether it rises or falls, sets `irq_flag`. The flag stays set until it is cleared.
- R6: `irq_clr` = 1 for one cycle clears `irq_flag` on the next edge. A lock change in the same cycle takes priority and keeps the flag set.
- R7: `irq` equals `irq_flag` AND `irq_en`. `irq_en` has no effect on `irq_flag`.
- R8: If no reference rising edge is seen for `ref_timeout` system cycles, `ref_lost` goes to 1, `lock` is forced to 0 and the window restarts. `ref_lost` returns to 0 at the next reference edge. `lock` cannot be 1 while `ref_lost` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4× either sampled clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Reference clock, asynchronous |
| fb_clk | input | 1 | Feedback clock, asynchronous |
| ref_timeout | input | TMO_W | Loss-of-reference limit in system cycles |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| lock | output | 1 | Read-only lock status |
| irq_flag | output | 1 | Sticky lock-change flag |
| irq | output | 1 | Interrupt request |
| ref_lost | output | 1 | Reference loss indication |

## Verification
The two synchronizers and the edge detector delay every input edge by two to three system cycles. A lock decision therefore lands at the end of a window, up to one full window plus one arming period after the feedback frequency changes, and the count can be off by one edge. The bench never samples a lock result at an exact cycle. It waits at least three windows after each frequency change and picks frequencies whose counts stay inside the intended band even with a one-edge error. Results that follow a single edge are sampled one or two cycles later, on the falling clock edge. These include the flag clear, the `irq` gating and the `ref_lost` clear after the reference returns. The loss timeout is checked on both sides of its limit, with margins wider than one reference period.

// File: rtl/pll_lock_detector.sv
module pll_lock_detector #(
  parameter int unsigned WIN_REF   = 8,
  parameter int unsigned FB_EXPECT = 32,
  parameter int unsigned TOL_LOCK  = 1,
  parameter int unsigned TOL_UNL   = 5,
  parameter int unsigned TMO_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             fb_clk,
  input  logic [TMO_W-1:0] ref_timeout,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             lock,
  output logic             irq_flag,
  output logic             irq,
  output logic             ref_lost
);
  localparam int REF_W = $clog2(WIN_REF + 1);
  localparam int FB_W  = $clog2(FB_EXPECT + TOL_UNL + 2) + 1;

  logic [2:0] ref_sync, fb_sync;
  logic ref_rise, fb_rise;
  logic [TMO_W-1:0] tmo_cnt;
  logic [REF_W-1:0] ref_cnt;
  logic [FB_W-1:0]  fb_cnt, err;
  logic armed, win_end, lost_evt, restart, lock_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_sync <= '0;
      fb_sync  <= '0;
    end else begin
      ref_sync <= {ref_sync[1:0], ref_clk};
      fb_sync  <= {fb_sync[1:0], fb_clk};
    end

  assign ref_rise = ref_sync[1] & ~ref_sync[2];
  assign fb_rise  = fb_sync[1] & ~fb_sync[2];

  assign lost_evt = !ref_rise && !ref_lost &&
                    ({1'b0, tmo_cnt} + 1'b1 == {1'b0, ref_timeout});
  assign win_end  = ref_rise && armed && (ref_cnt == REF_W'(WIN_REF - 1));
  assign restart  = ref_rise && (!armed || win_end);

  assign err = (fb_cnt >= FB_W'(FB_EXPECT)) ? fb_cnt - FB_W'(FB_EXPECT)
                                            : FB_W'(FB_EXPECT) - fb_cnt;

  always_comb begin
    lock_nxt = lock;
    if (lost_evt)
      lock_nxt = 1'b0;
    else if (win_end)
      lock_nxt = lock ? !(err > FB_W'(TOL_UNL)) : (err <= FB_W'(TOL_LOCK));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo_cnt  <= '0;
      ref_lost <= 1'b0;
      armed    <= 1'b0;
      ref_cnt  <= '0;
      fb_cnt   <= '0;
      lock     <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (ref_rise)               tmo_cnt <= '0;
      else if (tmo_cnt != '1)     tmo_cnt <= tmo_cnt + 1'b1;

      if (lost_evt)               ref_lost <= 1'b1;
      else if (ref_rise)          ref_lost <= 1'b0;

      if (lost_evt)               armed <= 1'b0;
      else if (ref_rise)          armed <= 1'b1;

      if (lost_evt || restart)    ref_cnt <= '0;
      else if (ref_rise)          ref_cnt <= ref_cnt + 1'b1;

      if (lost_evt)               fb_cnt <= '0;
      else if (restart)           fb_cnt <= FB_W'(fb_rise);
      else if (fb_rise && fb_cnt != '1) fb_cnt <= fb_cnt + 1'b1;

      lock <= lock_nxt;

      if (lock_nxt != lock)       irq_flag <= 1'b1;
      else if (irq_clr)           irq_flag <= 1'b0;
    end

  assign irq = irq_flag & irq_en;
endmodule

module pll_lock_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic lock,
  input logic irq_flag,
  input logic irq_clr,
  input logic ref_lost,
  input logic win_end,
  input logic lost_evt
);
  a_r8_lost_means_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ref_lost |-> !lock);
  a_r4_change_only_at_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != $past(lock)) |-> $past(win_end || lost_evt));
  a_r5_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (lock != $past(lock)) |-> irq_flag);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag);
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> (!irq_flag || lock != $past(lock)));
endmodule

bind pll_lock_detector pll_lock_detector_chk chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .irq_flag(irq_flag),
  .irq_clr(irq_clr), .ref_lost(ref_lost), .win_end(win_end), .lost_evt(lost_evt)
);

// File: tb/tb_pll_lock_detector.sv
`timescale 1ns/1ps
module tb_pll_lock_detector;
  logic clk = 0, rst_n = 0, ref_clk = 0, fb_clk = 0;
  logic [11:0] ref_timeout = 12'd50;
  logic irq_en = 0, irq_clr = 0;
  logic lock, irq_flag, irq, ref_lost;
  int total = 0, bad = 0;
  bit ref_run = 1;
  realtime ref_hp = 100.0;
  realtime fb_hp  = 25.0;
  localparam realtime HP_EXACT = 25.0;
  localparam realtime HP_SLIGHT = 22.857;
  localparam realtime HP_FAR = 32.0;

  pll_lock_detector dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2.3;
    forever begin
      if (ref_run) begin #(ref_hp); ref_clk = ~ref_clk; end
      else begin ref_clk = 0; #1; end
    end
  end

  initial begin
    #2.3;
    forever begin #(fb_hp); fb_clk = ~fb_clk; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cycles(3);
    rst_n = 1;
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic t_reset();
    fb_hp = HP_EXACT;
    do_reset();
    check("R1 lock", lock, 0);
    check("R1 irq_flag", irq_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 ref_lost", ref_lost, 0);
    cycles(100);
    check("R2 no decision before first window", lock, 0);
  endtask

  task automatic t_acquire();
    irq_en = 1;
    cycles(600);
    check("R3 lock at exact ratio", lock, 1);
    check("R5 flag on rise", irq_flag, 1);
    check("R7 irq with enable", irq, 1);
  endtask

  task automatic t_clear();
    pulse_clr();
    cycles(1);
    check("R6 flag cleared", irq_flag, 0);
    check("R6 irq dropped", irq, 0);
  endtask

  task automatic t_hold_slight();
    int drops = 0;
    fb_hp = HP_SLIGHT;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (!lock || irq_flag) drops++;
    end
    check("R4 hysteresis holds lock", drops, 0);
    check("R4 lock still set", lock, 1);
  endtask

  task automatic t_drop_far();
    irq_en = 0;
    fb_hp = HP_FAR;
    cycles(600);
    check("R4 unlock when far", lock, 0);
    check("R5 flag on fall", irq_flag, 1);
    check("R7 irq masked", irq, 0);
    irq_en = 1;
    cycles(1);
    check("R7 irq after enable", irq, 1);
    pulse_clr();
    cycles(1);
    check("R6 flag cleared after fall", irq_flag, 0);
  endtask

  task automatic t_no_acquire_slight();
    int sets = 0;
    fb_hp = HP_SLIGHT;
    do_reset();
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (lock || irq_flag) sets++;
    end
    check("R3 no lock outside tight band", sets, 0);
  endtask

  task automatic t_loss_locked();
    fb_hp = HP_EXACT;
    cycles(600);
    check("R3 relock at exact ratio", lock, 1);
    pulse_clr();
    ref_run = 0;
    cycles(20);
    check("R8 not lost before timeout", ref_lost, 0);
    check("R8 lock held before timeout", lock, 1);
    cycles(60);
    check("R8 loss flagged", ref_lost, 1);
    check("R8 lock forced low", lock, 0);
    check("R5 flag on forced unlock", irq_flag, 1);
    pulse_clr();
  endtask

  task automatic t_ref_return();
    ref_run = 1;
    cycles(40);
    check("R8 loss clears on edge", ref_lost, 0);
    check("R8 no lock before a full window", lock, 0);
    cycles(600);
    check("R8 relock after return", lock, 1);
  endtask

  task automatic t_loss_unlocked();
    fb_hp = HP_FAR;
    cycles(600);
    check("R4 unlocked far again", lock, 0);
    pulse_clr();
    ref_run = 0;
    cycles(100);
    check("R8 loss while unlocked", ref_lost, 1);
    check("R5 no flag without lock change", irq_flag, 0);
    ref_run = 1;
    cycles(40);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_clear();
    t_hold_slight();
    t_drop_far();
    t_no_acquire_slight();
    t_loss_locked();
    t_ref_return();
    t_loss_unlocked();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule